// File: doc/BRIEF.md
# Key-Protected Flash Control Register Front-End

This block sits between a 32-bit register bus and a flash program/erase engine. It holds the control word and the option-control word that the engine acts on. Neither word can be changed until software has written a fixed pair of 32-bit keys, in the right order, to that word's own key register. A wrong key or a pair in the wrong order jams that unlock path until the next reset.

Completion and error events from the engine arrive as one-cycle pulses and set sticky flags in a status register. The bus cannot write the status register. Software clears flags by writing ones to a separate clear register, and an event in the same cycle as a clear keeps its flag set. Reads are combinational from the register address. Writes take effect on the clock edge where write-enable is high.

Top module: `flashif_top`

## Requirements
- R1: After reset, the control register (offset 0x0C) and the option-control register (offset 0x18) read as 0x00000001 (lock flag at bit 0 set), and the status register (offset 0x10) reads 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) clears the control lock flag. After that, a write to the control register stores all bits 31:1 as written.
- R3: While the control lock flag is set, writes to the control register leave its contents unchanged.
- R4: A first key other than 0x45670123 (including 0xCDEF89AB written first), or a second key other than 0xCDEF89AB, keeps the control register locked until reset, even if a correct pair is written later.
- R5: Writing the control register with bit 0 set while it is unlocked stores bits 31:1 and sets the lock flag. A later correct key pair unlocks it again.
- R6: The option-control register unlocks only with 0x08192A3B then 0x4C5D6E7F written to the option key register (offset 0x08). Its lock flag is bit 0, and it relocks and holds its contents the same way as the control register. The control keys written there do not unlock it.
- R7: Bus writes to the status register have no effect.
- R8: Event input bits 0..5 set status bits 16, 17, 18, 19, 21 and 22 respectively (end-of-operation, write-protect, program-sequence, strobe, inconsistency and operation errors). Each flag stays set until cleared.
- R9: Writing the clear register (offset 0x14) clears exactly the status bits whose positions are written as 1.
- R10: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R11: Key writes while a register is already unlocked leave it unlocked.
- R12: The key, option key and clear registers read as 0. Status bits outside the six defined positions always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_i | input | 6 | One-cycle engine event pulses |
| ctrl_o | output | 32 | Control word to the engine (bit 0 = locked) |
| optctl_o | output | 32 | Option-control word to the engine (bit 0 = locked) |

## Verification
The hardest state to reach from the ports is the jammed key path. Once it is jammed, nothing but reset recovers it, so each way of jamming needs a fresh reset. The stimulus resets the block between the reversed-order, bad-second-key and bad-first-key cases, and then writes a correct pair to show the jam holds. The event-against-clear race is forced by driving an event pulse and a clear-register write in the same bus cycle.

// File: rtl/flashif_pkg.sv
`timescale 1ns/1ps
package flashif_pkg;

  localparam int DATA_W  = 32;
  localparam int NUM_EVT = 6;

  localparam int OFS_KEY    = 'h04;
  localparam int OFS_OPTKEY = 'h08;
  localparam int OFS_CTRL   = 'h0C;
  localparam int OFS_STAT   = 'h10;
  localparam int OFS_CLR    = 'h14;
  localparam int OFS_OPTCTL = 'h18;

  localparam logic [DATA_W-1:0] CTRL_KEY_A = 32'h4567_0123;
  localparam logic [DATA_W-1:0] CTRL_KEY_B = 32'hCDEF_89AB;
  localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
  localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_FIRST = 2'd1,
    KS_OPEN  = 2'd2,
    KS_JAM   = 2'd3
  } key_state_e;

  // status bit position of each engine event
  function automatic int evt_bit(input int idx);
    case (idx)
      0:       return 16;
      1:       return 17;
      2:       return 18;
      3:       return 19;
      4:       return 21;
      default: return 22;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[evt_bit(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/flashif_keyseq.sv
`timescale 1ns/1ps
module flashif_keyseq
  import flashif_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = 32'h0,
  parameter logic [DATA_W-1:0] KEY_B = 32'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  input  logic              relock,
  output logic              locked_o
);

  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      KS_IDLE:  if (key_we) st_d = (key_data == KEY_A) ? KS_FIRST : KS_JAM;
      KS_FIRST: if (key_we) st_d = (key_data == KEY_B) ? KS_OPEN  : KS_JAM;
      KS_OPEN:  if (relock) st_d = KS_IDLE;
      default:  st_d = KS_JAM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign locked_o = (st_q != KS_OPEN);

  AST_JAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_JAM) |=> (st_q == KS_JAM)); // R4
  AST_OPEN_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(key_we && key_data == KEY_B)); // R2
  AST_OPEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && !relock) |=> !locked_o); // R11

endmodule

// File: rtl/flashif_status.sv
`timescale 1ns/1ps
module flashif_status
  import flashif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_en,
  input  logic [DATA_W-1:0]  clr_mask,
  output logic [DATA_W-1:0]  stat_o
);

  localparam logic [DATA_W-1:0] IMPL = impl_mask();

  logic [DATA_W-1:0] onehot [NUM_EVT];
  logic [DATA_W-1:0] set_vec, stat_q, stat_d;
  logic              stat_en;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    assign onehot[g] = evt_i[g] ? (DATA_W'(1) << evt_bit(g)) : '0;
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_EVT; i++) set_vec = set_vec | onehot[i];
  end

  always_comb begin
    stat_en = clr_en | (|evt_i);
    stat_d  = ((stat_q & ~(clr_en ? clr_mask : '0)) | set_vec) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R10
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(|evt_i)) |=> ((stat_q & $past(clr_mask)) == '0)); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~IMPL) == '0)); // R12

endmodule

// File: rtl/flashif_top.sv
`timescale 1ns/1ps
module flashif_top
  import flashif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0]  optctl_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic sel_key, sel_optkey, sel_ctrl, sel_clr, sel_optctl;
  assign sel_key    = (bus_addr == ADDR_W'(OFS_KEY));
  assign sel_optkey = (bus_addr == ADDR_W'(OFS_OPTKEY));
  assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_clr    = (bus_addr == ADDR_W'(OFS_CLR));
  assign sel_optctl = (bus_addr == ADDR_W'(OFS_OPTCTL));

  logic ctrl_locked, opt_locked;
  logic ctrl_wen, opt_wen;
  logic [DATA_W-1:1] ctrl_bits_q, ctrl_bits_d, opt_bits_q, opt_bits_d;
  logic [DATA_W-1:0] stat;

  assign ctrl_wen = bus_we & sel_ctrl   & ~ctrl_locked;
  assign opt_wen  = bus_we & sel_optctl & ~opt_locked;

  flashif_keyseq #(.KEY_A(CTRL_KEY_A), .KEY_B(CTRL_KEY_B)) u_ctrl_keys (
    .clk      (clk),
    .rst_n    (rst_sn),
    .key_we   (bus_we & sel_key),
    .key_data (bus_wdata),
    .relock   (ctrl_wen & bus_wdata[0]),
    .locked_o (ctrl_locked)
  );

  flashif_keyseq #(.KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) u_opt_keys (
    .clk      (clk),
    .rst_n    (rst_sn),
    .key_we   (bus_we & sel_optkey),
    .key_data (bus_wdata),
    .relock   (opt_wen & bus_wdata[0]),
    .locked_o (opt_locked)
  );

  flashif_status u_status (
    .clk      (clk),
    .rst_n    (rst_sn),
    .evt_i    (evt_i),
    .clr_en   (bus_we & sel_clr),
    .clr_mask (bus_wdata),
    .stat_o   (stat)
  );

  always_comb begin
    ctrl_bits_d = ctrl_wen ? bus_wdata[DATA_W-1:1] : ctrl_bits_q;
    opt_bits_d  = opt_wen  ? bus_wdata[DATA_W-1:1] : opt_bits_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_bits_q <= '0;
      opt_bits_q  <= '0;
    end else begin
      if (ctrl_wen) ctrl_bits_q <= ctrl_bits_d;
      if (opt_wen)  opt_bits_q  <= opt_bits_d;
    end
  end

  assign ctrl_o   = {ctrl_bits_q, ctrl_locked};
  assign optctl_o = {opt_bits_q, opt_locked};

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_CTRL):   bus_rdata = ctrl_o;
      ADDR_W'(OFS_STAT):   bus_rdata = stat;
      ADDR_W'(OFS_OPTCTL): bus_rdata = optctl_o;
      default:             bus_rdata = '0;
    endcase
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl_locked |=> $stable(ctrl_bits_q)); // R3
  AST_OPT_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    opt_locked |=> $stable(opt_bits_q)); // R6
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ctrl_locked && bus_we && sel_ctrl && bus_wdata[0]) |=> ctrl_o[0]); // R5

endmodule

// File: tb/flashif_top_bench.sv
`timescale 1ns/1ps
module flashif_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  evt_i = '0;
  logic [31:0] ctrl_o, optctl_o;
  logic        rd_act = 1'b0;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk; // 50 MHz

  flashif_top u_flashif_top (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .ctrl_o(ctrl_o), .optctl_o(optctl_o)
  );

  localparam logic [7:0] A_KEY = 8'h04, A_OKEY = 8'h08, A_CTRL = 8'h0C,
                         A_STAT = 8'h10, A_CLR = 8'h14, A_OCTL = 8'h18;
  localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB,
                          OK1 = 32'h0819_2A3B, OK2 = 32'h4C5D_6E7F;

  // monitor: samples mid-cycle, pops expected item
  always begin
    @(posedge clk);
    #5;
    if (rd_act) begin
      item_t it;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL monitor: read with empty queue, got %h expected none", bus_rdata);
      end else begin
        it = q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [5:0] e,
                        input logic we);
    @(negedge clk);
    rd_act = 1'b0; bus_we = we; bus_addr = a; bus_wdata = d; evt_i = e;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_evt(a, d, 6'd0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0; evt_i = '0; bus_addr = a; rd_act = 1'b1;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rd_act = 1'b0; bus_we = 1'b0; evt_i = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset values
    rd(A_CTRL, 32'h1, "R1 ctrl reset");
    rd(A_OCTL, 32'h1, "R1 optctl reset");
    rd(A_STAT, 32'h0, "R1 status reset");
    // R3 locked write ignored
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, 32'h1, "R3 locked ctrl write");
    // R2 unlock and write
    wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTRL, 32'h0, "R2 unlocked");
    wr(A_CTRL, 32'h0000_00F2);
    rd(A_CTRL, 32'h0000_00F2, "R2 ctrl write");
    // R11 extra key write while open
    wr(A_KEY, K1);
    rd(A_CTRL, 32'h0000_00F2, "R11 key while open");
    // R5 relock and re-unlock
    wr(A_CTRL, 32'h0000_0301);
    rd(A_CTRL, 32'h0000_0301, "R5 relock");
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, 32'h0000_0301, "R5 relocked holds");
    wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTRL, 32'h0000_0300, "R5 unlock again");
    // R6 option path
    rd(A_OCTL, 32'h1, "R6 opt still locked");
    wr(A_OCTL, 32'h0000_00A4);
    rd(A_OCTL, 32'h1, "R6 opt locked write");
    wr(A_OKEY, OK1); wr(A_OKEY, OK2);
    rd(A_OCTL, 32'h0, "R6 opt unlocked");
    wr(A_OCTL, 32'h0000_00A4);
    rd(A_OCTL, 32'h0000_00A4, "R6 opt write");
    wr(A_OCTL, 32'h0000_0005);
    rd(A_OCTL, 32'h0000_0005, "R6 opt relock");
    // R8 event mapping
    wr_evt(A_STAT, 0, 6'b000001, 1'b0);
    rd(A_STAT, 32'h0001_0000, "R8 end-of-op bit16");
    wr_evt(A_STAT, 0, 6'b010000, 1'b0);
    rd(A_STAT, 32'h0021_0000, "R8 bit21");
    wr_evt(A_STAT, 0, 6'b101110, 1'b0);
    rd(A_STAT, 32'h006F_0000, "R8 all bits");
    // R7 status write ignored
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h006F_0000, "R7 status write");
    // R9 selective clear
    wr(A_CLR, 32'h0002_0000);
    rd(A_STAT, 32'h006D_0000, "R9 clear bit17");
    // R10 event vs clear
    wr_evt(A_CLR, 32'hFFFF_FFFF, 6'b100000, 1'b1);
    rd(A_STAT, 32'h0040_0000, "R10 event wins");
    // R12 zero-reading registers
    rd(A_CLR, 32'h0, "R12 clear reads 0");
    rd(A_KEY, 32'h0, "R12 key reads 0");
    rd(A_OKEY, 32'h0, "R12 opt key reads 0");
    // R4 reversed order
    do_reset();
    rd(A_CTRL, 32'h1, "R1 ctrl after reset");
    wr(A_KEY, K2); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTRL, 32'h1, "R4 reversed order");
    wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTRL, 32'h1, "R4 jam persists");
    // R4 bad second key
    do_reset();
    wr(A_KEY, K1); wr(A_KEY, 32'h1234_5678); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTRL, 32'h1, "R4 bad second key");
    // R4 bad first key, R6 ctrl keys on option path
    do_reset();
    wr(A_KEY, 32'h0); wr(A_KEY, K1); wr(A_KEY, K2);
    rd(A_CTRL, 32'h1, "R4 bad first key");
    wr(A_OKEY, K1); wr(A_OKEY, K2);
    rd(A_OCTL, 32'h1, "R6 ctrl keys on opt path");
    @(negedge clk);
    rd_act = 1'b0;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule